// File: doc/BRIEF.md
# Secondary Interrupt Concentrator with Line Bypass

This block collects 32 level-sensitive interrupt requests and presents them to a primary interrupt controller in two ways. First, it captures every input's level in a raw-level register, filters that register through a software-programmed enable mask, and raises a single combined request on output line 31 whenever any enabled input is high. Second, a window of inputs (lines 21 through 30) can be switched into bypass, so that each such input drives its own matching output line straight to the primary controller, whatever the enable mask holds.

Software reaches the block through a simple synchronous register bus over a 4 KB window. The word index is the byte address shifted right by two. Registers are written through set and clear pairs, so that no read-modify-write is needed. A one-bit software interrupt pair acts on bit 0 of the enable mask. The primary controller, edge detection and priority encoding sit outside this block.

Top module: `sic_top`

## Requirements
- R1: The raw-level register takes the value of `irqIn` at every clock edge. A read at word index 1 returns it.
- R2: A read at word index 0 returns the raw level ANDed with the enable mask.
- R3: A write at word index 2 ORs the write data into the enable mask. A read at word index 2 returns the mask.
- R4: A write at word index 3 clears each enable-mask bit that is 1 in the write data.
- R5: A read at word index 4 returns raw-level bit 0 in bit 0, with all other bits zero. A write of any nonzero value at index 4 sets mask bit 0. A nonzero write at index 5 clears mask bit 0. A zero write at index 4 or 5 changes nothing.
- R6: A write at word index 8 ORs into the bypass-enable register only the bits of the write data within 21..30 (mask 0x7FE00000). A read at index 8 returns the bypass-enable register.
- R7: A write at word index 9 clears each bypass-enable bit that is 1 in the write data.
- R8: While its bypass bit is set, output line i (21..30) equals raw-level bit i. When a bypass bit is set, the line is re-driven from the current raw level. When the bypass bit is cleared, the line holds its last driven value. Lines 0..20 stay low.
- R9: `irqOut[31]` is high exactly when the raw level ANDed with the enable mask is nonzero. It reflects an input change or a mask write in the cycle after the register updates, with no further delay.
- R10: Reads at word indices other than 0, 1, 2, 4 and 8 return zero. Writes at indices other than 2, 3, 4, 5, 8 and 9 change no state.
- R11: Reset clears the raw level, the enable mask, the bypass-enable register and all outputs. Read data is valid in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 32 | Level-sensitive interrupt requests |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address within the window |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data, valid the cycle after a read strobe |
| irqOut | output | 32 | Line 31 is the combined request; lines 21..30 are bypass lines; lines 0..20 are low |

## Verification
The combined request is driven with input patterns that do and do not overlap the mask, and with inputs that toggle only bit 0. This separates a status computed with AND from one computed with OR or from raw levels, and confirms that the software pair acts on mask bit 0 alone. The bypass path is tried with a set write of all ones, so that any leak outside 21..30 shows up. It is then tried with inputs that change on enabled lines, on cleared lines and on re-enabled lines, which separates "follow", "hold" and "re-drive from current level". Writes of all ones to unmapped indices, followed by read-back of every register, expose any decoder aliasing.

// File: rtl/sic_pkg.sv
package sic_pkg;

  localparam int IDX_STATUS   = 0;
  localparam int IDX_RAW      = 1;
  localparam int IDX_ENSET    = 2;
  localparam int IDX_ENCLR    = 3;
  localparam int IDX_SOFTSET  = 4;
  localparam int IDX_SOFTCLR  = 5;
  localparam int IDX_PASSSET  = 8;
  localparam int IDX_PASSCLR  = 9;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_STATUS,
    RD_RAW,
    RD_MASK,
    RD_SOFT,
    RD_PASS
  } rdSel_e;

  typedef struct packed {
    logic   maskSet;
    logic   maskClr;
    logic   softSet;
    logic   softClr;
    logic   passSet;
    logic   passClr;
    logic   rdStrobe;
    rdSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/sic_ctrl.sv
module sic_ctrl
  import sic_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  output ctrlStrobes_t      strobes
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             wrEn;
  logic             rdEn;
  logic             dataNonZero;
  logic             unusedLowBits;

  assign wordIdx       = busAddr[ADDR_W-1:2];
  assign unusedLowBits = ^busAddr[1:0];
  assign wrEn          = busSel && busWrite;
  assign rdEn          = busSel && !busWrite;
  assign dataNonZero   = |busWData;

  always_comb begin
    strobes          = '0;
    strobes.rdSel    = RD_ZERO;
    strobes.rdStrobe = rdEn;
    if (wrEn) begin
      case (wordIdx)
        IDX_W'(IDX_ENSET):   strobes.maskSet = 1'b1;
        IDX_W'(IDX_ENCLR):   strobes.maskClr = 1'b1;
        IDX_W'(IDX_SOFTSET): strobes.softSet = dataNonZero;
        IDX_W'(IDX_SOFTCLR): strobes.softClr = dataNonZero;
        IDX_W'(IDX_PASSSET): strobes.passSet = 1'b1;
        IDX_W'(IDX_PASSCLR): strobes.passClr = 1'b1;
        default: ;
      endcase
    end
    if (rdEn) begin
      case (wordIdx)
        IDX_W'(IDX_STATUS):  strobes.rdSel = RD_STATUS;
        IDX_W'(IDX_RAW):     strobes.rdSel = RD_RAW;
        IDX_W'(IDX_ENSET):   strobes.rdSel = RD_MASK;
        IDX_W'(IDX_SOFTSET): strobes.rdSel = RD_SOFT;
        IDX_W'(IDX_PASSSET): strobes.rdSel = RD_PASS;
        default:             strobes.rdSel = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/sic_datapath.sv
module sic_datapath
  import sic_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PASS_LO   = 21,
  parameter int PASS_HI   = 30
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic [NUM_LINES-1:0] wData,
  input  ctrlStrobes_t         strobes,
  output logic [NUM_LINES-1:0] rData,
  output logic                 anyActive,
  output logic [NUM_LINES-1:0] passOut
);

  function automatic logic [NUM_LINES-1:0] mkWindow();
    logic [NUM_LINES-1:0] w;
    w = '0;
    for (int i = PASS_LO; i <= PASS_HI; i++) w[i] = 1'b1;
    return w;
  endfunction

  localparam logic [NUM_LINES-1:0] PASS_WIN = mkWindow();

  logic [NUM_LINES-1:0] levelQ;
  logic [NUM_LINES-1:0] maskQ,   maskD;
  logic [NUM_LINES-1:0] passEnQ, passEnD;

  always_comb begin
    maskD = maskQ;
    if (strobes.maskSet) maskD = maskD | wData;
    if (strobes.maskClr) maskD = maskD & ~wData;
    if (strobes.softSet) maskD[0] = 1'b1;
    if (strobes.softClr) maskD[0] = 1'b0;
  end

  always_comb begin
    passEnD = passEnQ;
    if (strobes.passSet) passEnD = passEnD | (wData & PASS_WIN);
    if (strobes.passClr) passEnD = passEnD & ~wData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ  <= '0;
      maskQ   <= '0;
      passEnQ <= '0;
    end else begin
      levelQ  <= irqIn;
      maskQ   <= maskD;
      passEnQ <= passEnD;
    end
  end

  // Per-line bypass drivers, present only inside the window
  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    if (g >= PASS_LO && g <= PASS_HI) begin : gPass
      logic lineQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           lineQ <= 1'b0;
        else if (passEnD[g]) lineQ <= irqIn[g];
      end
      assign passOut[g] = lineQ;

      AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
        passEnQ[g] |-> (passOut[g] == levelQ[g]));  // R8
    end else begin : gTie
      assign passOut[g] = 1'b0;
    end
  end

  assign anyActive = |(levelQ & maskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rData <= '0;
    end else if (strobes.rdStrobe) begin
      case (strobes.rdSel)
        RD_STATUS: rData <= levelQ & maskQ;
        RD_RAW:    rData <= levelQ;
        RD_MASK:   rData <= maskQ;
        RD_SOFT:   rData <= {{(NUM_LINES-1){1'b0}}, levelQ[0]};
        RD_PASS:   rData <= passEnQ;
        default:   rData <= '0;
      endcase
    end
  end

  AST_RAW_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (levelQ == $past(irqIn)));  // R1

  AST_MASK_SET_OR: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.maskSet && !strobes.maskClr) |=> ((maskQ & $past(wData)) == $past(wData)));  // R3

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskClr |=> ((maskQ & $past(wData)) == '0));  // R4

  AST_PASS_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (passEnQ & ~PASS_WIN) == '0);  // R6

  AST_PASS_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.passClr |=> ((passEnQ & $past(wData)) == '0));  // R7

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.maskSet || strobes.maskClr || strobes.softSet || strobes.softClr ||
      strobes.passSet || strobes.passClr) |=> ($stable(maskQ) && $stable(passEnQ)));  // R10

endmodule

// File: rtl/sic_top.sv
module sic_top
  import sic_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 12,
  parameter int PASS_LO   = 21,
  parameter int PASS_HI   = 30
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [NUM_LINES-1:0] busWData,
  output logic [NUM_LINES-1:0] busRData,
  output logic [NUM_LINES-1:0] irqOut
);

  localparam int COMB_LINE = NUM_LINES - 1;

  ctrlStrobes_t         strobes;
  logic                 anyActive;
  logic [NUM_LINES-1:0] passOut;

  sic_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (NUM_LINES)
  ) uCtrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWData (busWData),
    .strobes  (strobes)
  );

  sic_datapath #(
    .NUM_LINES (NUM_LINES),
    .PASS_LO   (PASS_LO),
    .PASS_HI   (PASS_HI)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .wData     (busWData),
    .strobes   (strobes),
    .rData     (busRData),
    .anyActive (anyActive),
    .passOut   (passOut)
  );

  always_comb begin
    irqOut            = passOut;
    irqOut[COMB_LINE] = anyActive;
  end

  logic unlistedRead;
  assign unlistedRead = busSel && !busWrite &&
    !(busAddr[ADDR_W-1:2] inside {(ADDR_W-2)'(IDX_STATUS), (ADDR_W-2)'(IDX_RAW),
                                  (ADDR_W-2)'(IDX_ENSET),  (ADDR_W-2)'(IDX_SOFTSET),
                                  (ADDR_W-2)'(IDX_PASSSET)});

  AST_UNLISTED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    unlistedRead |=> (busRData == '0));  // R10

  AST_LOW_LINES_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    irqOut[PASS_LO-1:0] == '0);  // R8

endmodule

// File: tb/tb_sic_top.sv
module tb_sic_top;

  localparam logic [31:0] WIN = 32'h7FE0_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic [31:0] irqOut;

  sic_top dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData), .irqOut(irqOut)
  );

  always #10 clk = ~clk;  // 50 MHz

  int nCompared = 0;
  int nMismatched = 0;
  bit summaryDone = 0;

  // reference model state
  logic [31:0] mLevel = '0, mMask = '0, mPass = '0, mPassOut = '0;

  typedef struct { logic [31:0] exp; string tag; } sbItem_t;
  sbItem_t sbQ[$];
  logic capFlag = 1'b0;

  function automatic logic [31:0] expOut();
    logic [31:0] e;
    e = mPassOut & WIN;
    e[31] = |(mLevel & mMask);
    return e;
  endfunction

  task automatic report();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  endtask

  // monitor: read data valid in the cycle after the strobe
  always @(posedge clk) capFlag <= busSel && !busWrite;

  always @(negedge clk) begin
    if (capFlag) begin
      sbItem_t it;
      if (sbQ.size() == 0) begin
        nCompared++; nMismatched++;
        $display("FAIL R11 unexpected read data act=%h exp=<none>", busRData);
      end else begin
        it = sbQ.pop_front();
        nCompared++;
        if (busRData !== it.exp) begin
          nMismatched++;
          $display("FAIL %s read act=%h exp=%h", it.tag, busRData, it.exp);
        end
      end
    end
  end

  task automatic chkOut(string tag);
    nCompared++;
    if (irqOut !== expOut()) begin
      nMismatched++;
      $display("FAIL %s irqOut act=%h exp=%h", tag, irqOut, expOut());
    end
  endtask

  task automatic setIrq(logic [31:0] v);
    @(negedge clk);
    irqIn = v;
    mLevel = v;
    mPassOut = (mPassOut & ~mPass) | (v & mPass);
    @(negedge clk);
  endtask

  task automatic regWrite(int idx, logic [31:0] v);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 12'(idx << 2); busWData = v;
    case (idx)
      2: mMask = mMask | v;
      3: mMask = mMask & ~v;
      4: if (v != 0) mMask[0] = 1'b1;
      5: if (v != 0) mMask[0] = 1'b0;
      8: begin
        mPass = mPass | (v & WIN);
        mPassOut = (mPassOut & ~mPass) | (mLevel & mPass);
      end
      9: mPass = mPass & ~v;
      default: ;
    endcase
    @(negedge clk);
    busSel = 0; busWrite = 0; busWData = '0;
  endtask

  task automatic regRead(int idx, string tag);
    sbItem_t it;
    case (idx)
      0: it.exp = mLevel & mMask;
      1: it.exp = mLevel;
      2: it.exp = mMask;
      4: it.exp = {31'b0, mLevel[0]};
      8: it.exp = mPass;
      default: it.exp = '0;
    endcase
    it.tag = tag;
    @(negedge clk);
    sbQ.push_back(it);
    busSel = 1; busWrite = 0; busAddr = 12'(idx << 2);
    @(negedge clk);
    busSel = 0;
  endtask

  initial begin
    #(20 * 200000);
    nCompared++; nMismatched++;
    $display("FAIL watchdog expired act=running exp=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chkOut("R11 reset outputs");
    regRead(0, "R11 reset status");
    regRead(1, "R11 reset raw");
    regRead(2, "R11 reset mask");
    regRead(8, "R11 reset bypass");

    setIrq(32'h0000_00F1);
    chkOut("R9 no mask no combined");
    regRead(1, "R1 raw level");
    regRead(0, "R2 status masked off");

    regWrite(2, 32'h0000_0011);
    chkOut("R9 combined rises");
    regRead(2, "R3 mask set");
    regRead(0, "R2 status overlap");
    regWrite(2, 32'h0000_0100);
    regRead(2, "R3 mask OR accumulate");
    regWrite(3, 32'h0000_0010);
    regRead(2, "R4 mask clear");

    setIrq(32'h0000_00F0);
    chkOut("R9 combined falls");
    regRead(4, "R5 soft read low");
    setIrq(32'h0000_00F1);
    regRead(4, "R5 soft read high");
    chkOut("R9 combined on bit0");
    regWrite(5, 32'h0);
    regRead(2, "R5 zero clear ignored");
    regWrite(5, 32'h0000_0080);
    regRead(2, "R5 soft clear");
    chkOut("R9 combined after soft clear");
    regWrite(4, 32'h0000_0002);
    regRead(2, "R5 soft set");

    regWrite(6, 32'hFFFF_FFFF);
    regWrite(10, 32'hFFFF_FFFF);
    regRead(2, "R10 mask untouched");
    regRead(8, "R10 bypass untouched");
    regRead(3, "R10 unlisted read 3");
    regRead(9, "R10 unlisted read 9");
    regRead(1023, "R10 unlisted read top");

    setIrq(32'h2060_00F1);
    chkOut("R8 bypass disabled lines low");
    regWrite(8, 32'hFFFF_FFFF);
    regRead(8, "R6 bypass window only");
    chkOut("R8 bypass re-driven on enable");
    setIrq(32'h4010_0001);
    chkOut("R8 bypass follows input");
    setIrq(32'h7FFF_FFFF);
    chkOut("R8 bypass all high");
    regWrite(9, 32'h0020_0000);
    regRead(8, "R7 bypass clear");
    setIrq(32'h0000_0000);
    chkOut("R8 cleared line holds");
    regWrite(2, 32'h2000_0000);
    setIrq(32'h2000_0000);
    chkOut("R9 high mask bit");
    regWrite(8, 32'h0020_0000);
    chkOut("R8 re-enable re-drives");
    regRead(0, "R2 status high bit");

    repeat (3) @(negedge clk);
    report();
  end

endmodule